// File: doc/BRIEF.md
# Quarter-Duty LCD Drive Sequencer

This block sequences the drive of a small multiplexed LCD glass with four backplanes (commons) and eleven segment lines, 44 cells in all, at 1/3 bias and 1/4 duty. It runs directly on a 32.768 kHz clock. It divides that clock down to the selected frame rate, steps through the four common phases of each frame, and inverts the drive polarity on alternate frames so that no cell sees a net DC voltage. It also runs the blink oscillator that gates flashing cells.

For every common and segment pin it emits a 2-bit code: 0 = VSS, 1 = VL1 (one third), 2 = VL2 (two thirds), 3 = VL3 (full). An external analog stage turns each code into the matching rail. Each cell's state comes from a segment-memory bit and a blink-memory bit. A global blank control forces every cell off. Two active-low test pins take precedence over everything else and force either all cells lit or one of two checkerboard patterns. When both pins return high, normal display resumes at once, with no reset and no disturbance to the timing.

Top module: `lcdQuarterDutyDriver`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, the block is in phase 0 of a positive frame with blinking cells visible: COM0 is at code 3 and the other commons are at code 1.
- R2: Each common phase lasts `PHASE_BASE >> frameSel` clock cycles. With the default PHASE_BASE of 256, `frameSel` = 0, 1, 2, 3 gives frame rates of 32, 64, 128 and 256 Hz. The phases select COM0, COM1, COM2, COM3 in that order, then wrap.
- R3: In a positive frame the selected common is at code 3 (VL3) and the unselected commons are at code 1 (VL1). In a negative frame these become code 0 (VSS) and code 2 (VL2). Exactly one common is ever at a rail level.
- R4: The frame polarity flips each time phase 3 ends, so positive and negative frames alternate.
- R5: A lit segment sits at the rail opposite the selected common: code 0 in a positive frame, code 3 in a negative frame. An unlit segment sits at code 2 in a positive frame and code 1 in a negative frame.
- R6: The cell at common c and segment s reads bit `s*4+c` of `segBits` and of `blinkBits`. With segment bit 0 the cell is off. With segment bit 1 and blink bit 0 it is lit. With both bits 1 it is lit only during the visible half of the blink period.
- R7: Each half of the blink period lasts `BLINK_BASE` cycles when `blinkSel` = 0 (0.5 Hz by default) and `BLINK_BASE/2` cycles when `blinkSel` = 1 (1 Hz). The visible half comes first after reset.
- R8: With `testPins` = 2'b11, setting `allOff` makes every cell unlit, whatever the memory holds.
- R9: With `testPins` = 2'b00, every cell is lit, regardless of memory, `allOff` and blink.
- R10: With `testPins` = 2'b01, cell bit i takes bit (i mod 8) of 8'hA5. With `testPins` = 2'b10, it takes bit (i mod 8) of 8'h5A. Memory, `allOff` and blink have no effect in either mode.
- R11: When `testPins` returns to 2'b11, the display follows memory again at once, and phase, polarity and blink timing continue without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz drive clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameSel | input | 2 | Frame-rate select (0 slowest .. 3 fastest) |
| blinkSel | input | 1 | Blink rate select (0 = slow, 1 = fast) |
| allOff | input | 1 | Blank every cell |
| testPins | input | 2 | Test-pattern select, 2'b11 = normal |
| segBits | input | 44 | Segment memory, bit s*4+c |
| blinkBits | input | 44 | Blink memory, bit s*4+c |
| comCode | output | 8 | Level code per common, COMc at [2c+1:2c] |
| segCode | output | 22 | Level code per segment, SEGs at [2s+1:2s] |

## Verification
The bench builds the block with PHASE_BASE = 8 and BLINK_BASE = 64. This shrinks a common phase to between 8 and 1 cycles and a blink half to 64 or 32 cycles. Every frame-rate and blink-rate pair can then be swept over several whole blink periods, and many polarity flips, in a few thousand cycles. At the fastest rate a frame lasts four cycles, so a one-hot walk over all 44 cells can check each cell against every common phase. The bench also exercises the blanking control and all three test patterns, then releases the test pins mid-run without a reset.

// File: rtl/lcdSeqPkg.sv
package lcdSeqPkg;
  localparam int LCD_COMS = 4;

  typedef enum logic [1:0] {
    LVL_VSS = 2'd0,
    LVL_VL1 = 2'd1,
    LVL_VL2 = 2'd2,
    LVL_VL3 = 2'd3
  } lcdLevelE;

  // strobes from timing control to level datapath
  typedef struct packed {
    logic [1:0] phaseIdx;
    logic       negFrame;
    logic       blinkVisible;
  } seqStrobeS;
endpackage

// File: rtl/lcdSeqCtrl.sv
module lcdSeqCtrl
  import lcdSeqPkg::*;
#(
  parameter int PHASE_BASE = 256,
  parameter int BLINK_BASE = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] frameSel,
  input  logic       blinkSel,
  output seqStrobeS  strobes
);
  localparam int PW = $clog2(PHASE_BASE + 1);
  localparam int BW = $clog2(BLINK_BASE + 1);

  logic [PW-1:0] phaseLen;
  logic [PW-1:0] phaseCnt;
  logic [BW-1:0] blinkLen;
  logic [BW-1:0] blinkCnt;
  logic [1:0]    phaseIdx;
  logic          negFrame;
  logic          blinkVisible;
  logic          phaseWrap;
  logic          blinkWrap;

  always_comb begin
    phaseLen  = PW'(PHASE_BASE) >> frameSel;
    blinkLen  = blinkSel ? BW'(BLINK_BASE / 2) : BW'(BLINK_BASE);
    phaseWrap = (phaseCnt >= phaseLen - PW'(1));
    blinkWrap = (blinkCnt >= blinkLen - BW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      phaseIdx <= '0;
      negFrame <= 1'b0;
    end else if (phaseWrap) begin
      phaseCnt <= '0;
      phaseIdx <= phaseIdx + 2'd1;
      if (phaseIdx == 2'd3) negFrame <= ~negFrame;
    end else begin
      phaseCnt <= phaseCnt + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkCnt     <= '0;
      blinkVisible <= 1'b1;
    end else if (blinkWrap) begin
      blinkCnt     <= '0;
      blinkVisible <= ~blinkVisible;
    end else begin
      blinkCnt <= blinkCnt + BW'(1);
    end
  end

  always_comb begin
    strobes.phaseIdx     = phaseIdx;
    strobes.negFrame     = negFrame;
    strobes.blinkVisible = blinkVisible;
  end
endmodule

// File: rtl/lcdSeqDatapath.sv
module lcdSeqDatapath
  import lcdSeqPkg::*;
#(
  parameter int NUM_SEG = 11
) (
  input  seqStrobeS                      strobes,
  input  logic                           allOff,
  input  logic [1:0]                     testPins,
  input  logic [LCD_COMS*NUM_SEG-1:0]    segBits,
  input  logic [LCD_COMS*NUM_SEG-1:0]    blinkBits,
  output logic [2*LCD_COMS-1:0]          comCode,
  output logic [2*NUM_SEG-1:0]           segCode
);
  localparam int NUM_CELLS = LCD_COMS * NUM_SEG;
  localparam logic [7:0] PAT_A = 8'hA5;
  localparam logic [7:0] PAT_B = 8'h5A;

  logic [NUM_CELLS-1:0] cellOn;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    always_comb begin
      unique case (testPins)
        2'b00:   cellOn[i] = 1'b1;
        2'b01:   cellOn[i] = PAT_A[i % 8];
        2'b10:   cellOn[i] = PAT_B[i % 8];
        default: cellOn[i] = ~allOff & segBits[i] &
                             (~blinkBits[i] | strobes.blinkVisible);
      endcase
    end
  end

  for (genvar c = 0; c < LCD_COMS; c++) begin : g_com
    always_comb begin
      if (strobes.phaseIdx == 2'(c))
        comCode[2*c +: 2] = strobes.negFrame ? LVL_VSS : LVL_VL3;
      else
        comCode[2*c +: 2] = strobes.negFrame ? LVL_VL2 : LVL_VL1;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [LCD_COMS-1:0] segCells;
    logic                litNow;
    always_comb begin
      segCells = cellOn[s*LCD_COMS +: LCD_COMS];
      litNow   = segCells[strobes.phaseIdx];
      if (litNow)
        segCode[2*s +: 2] = strobes.negFrame ? LVL_VL3 : LVL_VSS;
      else
        segCode[2*s +: 2] = strobes.negFrame ? LVL_VL1 : LVL_VL2;
    end
  end
endmodule

// File: rtl/lcdQuarterDutyDriver.sv
module lcdQuarterDutyDriver
  import lcdSeqPkg::*;
#(
  parameter int NUM_SEG    = 11,
  parameter int PHASE_BASE = 256,
  parameter int BLINK_BASE = 32768
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  frameSel,
  input  logic                        blinkSel,
  input  logic                        allOff,
  input  logic [1:0]                  testPins,
  input  logic [4*NUM_SEG-1:0]        segBits,
  input  logic [4*NUM_SEG-1:0]        blinkBits,
  output logic [7:0]                  comCode,
  output logic [2*NUM_SEG-1:0]        segCode
);
  seqStrobeS strobes;

  lcdSeqCtrl #(
    .PHASE_BASE(PHASE_BASE),
    .BLINK_BASE(BLINK_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameSel (frameSel),
    .blinkSel (blinkSel),
    .strobes  (strobes)
  );

  lcdSeqDatapath #(
    .NUM_SEG(NUM_SEG)
  ) u_dp (
    .strobes   (strobes),
    .allOff    (allOff),
    .testPins  (testPins),
    .segBits   (segBits),
    .blinkBits (blinkBits),
    .comCode   (comCode),
    .segCode   (segCode)
  );
endmodule

// File: rtl/lcdSeqChk.sv
module lcdSeqChk #(
  parameter int NUM_SEG = 11
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 allOff,
  input logic [1:0]           testPins,
  input logic [7:0]           comCode,
  input logic [2*NUM_SEG-1:0] segCode
);
  logic [3:0]         comRail;
  logic               negSeen;
  logic [NUM_SEG-1:0] segBit0;
  logic [NUM_SEG-1:0] segMid;
  logic [NUM_SEG-1:0] segRail;

  always_comb begin
    for (int c = 0; c < 4; c++)
      comRail[c] = (comCode[2*c +: 2] == 2'd0) || (comCode[2*c +: 2] == 2'd3);
    negSeen = 1'b0;
    for (int c = 0; c < 4; c++)
      if (comCode[2*c +: 2] == 2'd0) negSeen = 1'b1;
    for (int s = 0; s < NUM_SEG; s++) begin
      segBit0[s] = segCode[2*s];
      segMid[s]  = segCode[2*s+1] ^ segCode[2*s];
      segRail[s] = ~segMid[s];
    end
  end

  // R1
  reset_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> comCode == 8'b01_01_01_11);

  // R3
  one_rail_com_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(comRail) == 1);

  // R5
  seg_polarity_chk: assert property (@(posedge clk) disable iff (!rstN)
    segBit0 == {NUM_SEG{negSeen}});

  // R8
  blank_unlit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allOff && testPins == 2'b11) |-> (&segMid));

  // R9
  test_all_lit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testPins == 2'b00) |-> (&segRail));
endmodule

bind lcdQuarterDutyDriver lcdSeqChk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .allOff   (allOff),
  .testPins (testPins),
  .comCode  (comCode),
  .segCode  (segCode)
);

// File: tb/tb_lcdQuarterDutyDriver.sv
`timescale 1ns/1ps
module tb_lcdQuarterDutyDriver;
  localparam int NS    = 11;
  localparam int NC    = 4 * NS;
  localparam int PB    = 8;
  localparam int BB    = 64;
  localparam logic [7:0] PA = 8'hA5;
  localparam logic [7:0] PZ = 8'h5A;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    frameSel = 2'd0;
  logic          blinkSel = 1'b0;
  logic          allOff = 1'b0;
  logic [1:0]    testPins = 2'b11;
  logic [NC-1:0] segBits = '0;
  logic [NC-1:0] blinkBits = '0;
  logic [7:0]    comCode;
  logic [2*NS-1:0] segCode;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  lcdQuarterDutyDriver #(.NUM_SEG(NS), .PHASE_BASE(PB), .BLINK_BASE(BB)) dut (
    .clk(clk), .rstN(rstN), .frameSel(frameSel), .blinkSel(blinkSel),
    .allOff(allOff), .testPins(testPins), .segBits(segBits),
    .blinkBits(blinkBits), .comCode(comCode), .segCode(segCode));

  function automatic logic cellExp(input int i, input logic vis);
    case (testPins)
      2'b00:   return 1'b1;
      2'b01:   return PA[i % 8];
      2'b10:   return PZ[i % 8];
      default: return !allOff && segBits[i] && (!blinkBits[i] || vis);
    endcase
  endfunction

  task automatic checkNow(input string req);
    int L, H, ph;
    logic neg, vis, on;
    logic [7:0] eCom;
    logic [2*NS-1:0] eSeg;
    L   = PB >> frameSel;
    H   = blinkSel ? BB / 2 : BB;
    ph  = (n / L) % 4;
    neg = ((n / (4 * L)) % 2) == 1;
    vis = ((n / H) % 2) == 0;
    for (int c = 0; c < 4; c++)
      eCom[2*c +: 2] = (c == ph) ? (neg ? 2'd0 : 2'd3) : (neg ? 2'd2 : 2'd1);
    for (int s = 0; s < NS; s++) begin
      on = cellExp(s * 4 + ph, vis);
      eSeg[2*s +: 2] = on ? (neg ? 2'd3 : 2'd0) : (neg ? 2'd1 : 2'd2);
    end
    checks++;
    if (comCode !== eCom || segCode !== eSeg) begin
      fails++;
      $display("FAIL %s n=%0d com actual=%h expected=%h seg actual=%h expected=%h",
               req, n, comCode, eCom, segCode, eSeg);
    end
  endtask

  task automatic stepRng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    n = 0;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    n++;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state, with memory lit and blinking
    segBits = '1; blinkBits = '1;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    n = 0;
    checkNow("R1 during reset");
    doReset();
    checkNow("R1 after release");

    // R2 R3 R4 R5 R7 sweep over every rate pair with changing memory
    for (int fs = 0; fs < 4; fs++) begin
      for (int bs = 0; bs < 2; bs++) begin
        frameSel = 2'(fs); blinkSel = 1'(bs);
        doReset();
        for (int k = 0; k < 2 * BB + 8; k++) begin
          tick();
          checkNow("R2 R3 R4 R5 R7 sweep");
          if (k % 16 == 15) begin
            stepRng();
            segBits = rng[NC-1:0];
            blinkBits = rng[63:64-NC];
          end
        end
      end
    end

    // R6: one-hot walk over all cells at the fastest rate
    frameSel = 2'd3; blinkSel = 1'b1;
    blinkBits = '0;
    doReset();
    for (int i = 0; i < NC; i++) begin
      segBits = '0;
      segBits[i] = 1'b1;
      if (i % 3 == 0) blinkBits[i] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        tick();
        checkNow("R6 cell walk");
      end
      blinkBits = '0;
    end

    // R8: blanking with random memory
    frameSel = 2'd2; blinkSel = 1'b0;
    doReset();
    allOff = 1'b1;
    for (int k = 0; k < 40; k++) begin
      tick();
      checkNow("R8 all off");
      stepRng();
      segBits = rng[NC-1:0];
      blinkBits = rng[63:64-NC];
    end

    // R9 R10: test patterns ignore memory, blanking and blink
    for (int t = 0; t < 3; t++) begin
      testPins = 2'(t);
      for (int k = 0; k < 24; k++) begin
        tick();
        checkNow(t == 0 ? "R9 test all lit" : "R10 test pattern");
        allOff = ~allOff;
        stepRng();
        segBits = rng[NC-1:0];
        blinkBits = rng[63:64-NC];
      end
    end

    // R11: release test pins without reset, timing keeps running
    testPins = 2'b11;
    allOff = 1'b0;
    segBits = '1;
    blinkBits = rng[NC-1:0];
    #1;
    checkNow("R11 release");
    for (int k = 0; k < 80; k++) begin
      tick();
      checkNow("R11 resume");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule